// File: doc/BRIEF.md
# Gated Serial Pattern Recognizer

The block watches one serial bit per clock and raises a single output flag whenever the three most recent bits, oldest first, are 0, 1, 0. Matches may overlap, so the stream 0,1,0,1,0 reports two hits. A second pattern gates the first. Once the bits 1, 0, 0 have appeared in that order at any point since reset, the block locks and keeps its output low for good. Only a reset releases it.

The design is a Moore machine with seven named states. A synchronous reset returns it to the start state. The output flag is held in a register that is loaded from the decode of the next state. Each output value therefore refers to the bit sampled on the same edge, and it becomes visible just after that edge.

States and their meaning:
- `ST_START`: nothing seen since reset.
- `ST_ZERO`: the history ends in 0 and holds no useful 1.
- `ST_ZERO_ONE`: the history ends in 0,1.
- `ST_HIT`: the history ends in 0,1,0. This is the only state with output 1.
- `ST_ONE`: the history ends in 1.
- `ST_ONE_ZERO`: the history ends in 1,0.
- `ST_LOCKED`: the pattern 1,0,0 has been seen. This state absorbs every input.

Transitions, written as state, then input, then next state:

| From | Input 0 | Input 1 |
|---|---|---|
| `ST_START` | `ST_ZERO` | `ST_ONE` |
| `ST_ZERO` | `ST_ZERO` | `ST_ZERO_ONE` |
| `ST_ZERO_ONE` | `ST_HIT` | `ST_ONE` |
| `ST_HIT` | `ST_LOCKED` | `ST_ZERO_ONE` |
| `ST_ONE` | `ST_ONE_ZERO` | `ST_ONE` |
| `ST_ONE_ZERO` | `ST_LOCKED` | `ST_ZERO_ONE` |
| `ST_LOCKED` | `ST_LOCKED` | `ST_LOCKED` |

Top module: `gated_seq_recognizer`

## Requirements
- R1: While `rst_i` is high at a rising edge, `match_o` is 0 after that edge. The bit history is cleared, so no pattern can span a reset.
- R2: After the edge that samples bit k, `match_o` is 1 exactly when bits k-2, k-1 and k are 0, 1, 0 and the sequence 1, 0, 0 has not occurred since reset.
- R3: Overlapping matches are all reported. Input 0,1,0,1,0 from reset gives output 0,0,1,0,1.
- R4: The sequence 1,0,0 locks the block, also when it ends a match (0,1,0,0). The output is 0 on that edge and on every later edge until reset.
- R5: While locked, no input pattern, including 0,1,0, raises `match_o`. A reset then restores normal detection.
- R6: Long runs of a constant input never raise `match_o`. A run of 1s followed by 0,1,0 still reports a match on the final 0.
- R7: From reset, input 0,0,1,0,1,0,1,0,0,1,0 gives output 0,0,0,1,0,1,0,1,0,0,0. Input 1,1,0,1,1,0,1,0,0,1,0 gives 0,0,0,0,0,0,0,1,0,0,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit, sampled on each rising edge |
| match_o | output | 1 | Registered flag: recent bits were 0,1,0 and the block is not locked |

## Verification
The assertions assume that `bit_i` and `rst_i` are settled at every rising edge and that the first edge sees reset high. Reset is the only way out of the locked state, so the lock properties are stated with reset as their only exit. The bench changes inputs only on falling edges and pulses reset before each stimulus group. A reference model follows only the last three bits and a sticky lock flag. It is compared with the output once per clock, over the two reference streams, targeted runs and random streams.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    typedef enum logic [2:0] {
        ST_START    = 3'd0,
        ST_ZERO     = 3'd1,
        ST_ZERO_ONE = 3'd2,
        ST_HIT      = 3'd3,
        ST_ONE      = 3'd4,
        ST_ONE_ZERO = 3'd5,
        ST_LOCKED   = 3'd6
    } rcg_state_e;
endpackage

// File: rtl/rcg_next_state.sv
module rcg_next_state
    import rcg_pkg::*;
(
    input  rcg_state_e cur_i,
    input  logic       bit_i,
    output rcg_state_e nxt_o
);
    always_comb begin
        nxt_o = ST_LOCKED;
        unique case (cur_i)
            ST_START:    nxt_o = bit_i ? ST_ONE      : ST_ZERO;
            ST_ZERO:     nxt_o = bit_i ? ST_ZERO_ONE : ST_ZERO;
            ST_ZERO_ONE: nxt_o = bit_i ? ST_ONE      : ST_HIT;
            ST_HIT:      nxt_o = bit_i ? ST_ZERO_ONE : ST_LOCKED;
            ST_ONE:      nxt_o = bit_i ? ST_ONE      : ST_ONE_ZERO;
            ST_ONE_ZERO: nxt_o = bit_i ? ST_ZERO_ONE : ST_LOCKED;
            ST_LOCKED:   nxt_o = ST_LOCKED;
            default:     nxt_o = ST_LOCKED;
        endcase
    end
endmodule

// File: rtl/rcg_out_decode.sv
module rcg_out_decode
    import rcg_pkg::*;
(
    input  rcg_state_e st_i,
    output logic       hit_o
);
    always_comb begin
        hit_o = 1'b0;
        unique case (st_i)
            ST_HIT:  hit_o = 1'b1;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/gated_seq_recognizer.sv
module gated_seq_recognizer
    import rcg_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic bit_i,
    output logic match_o
);
    rcg_state_e state_q;
    rcg_state_e state_d;
    logic       hit_d;
    logic       match_q;

    rcg_next_state u_next (
        .cur_i (state_q),
        .bit_i (bit_i),
        .nxt_o (state_d)
    );

    rcg_out_decode u_dec (
        .st_i  (state_d),
        .hit_o (hit_d)
    );

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_START;
        else       state_q <= state_d;
    end

    // Output register, loaded from the decode of the next state
    always_ff @(posedge clk_i) begin
        if (rst_i) match_q <= 1'b0;
        else       match_q <= hit_d;
    end

    assign match_o = match_q;

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (state_q == ST_START && !match_o)); // R1

    AST_HIT_NEEDS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (!match_o && bit_i) |=> !match_o); // R2

    AST_MATCH_THEN_ZERO_LOCKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (match_o && !bit_i) |=> (state_q == ST_LOCKED && !match_o)); // R4

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LOCKED) |=> (state_q == ST_LOCKED)); // R5

    AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LOCKED) |-> !match_o); // R5

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (rst_i)
        match_o |=> !match_o); // R3
endmodule

// File: tb/gated_seq_recognizer_tb.sv
module gated_seq_recognizer_tb;
    localparam int PERIOD = 10;

    logic clk;
    logic rst;
    logic din;
    logic match;

    int checks = 0;
    int fails  = 0;
    int hist   = 0;
    int nbits  = 0;
    bit locked = 0;

    gated_seq_recognizer u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .bit_i   (din),
        .match_o (match)
    );

    initial clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: match_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        hist = 0; nbits = 0; locked = 0;
        check(req, match, 1'b0);
    endtask

    task automatic send(input string req, input logic b);
        logic exp;
        din = b;
        @(negedge clk);
        hist = ((hist << 1) | int'(b)) & 7;
        nbits++;
        if (nbits >= 3 && hist == 4) locked = 1;
        exp = (nbits >= 3 && hist == 2 && !locked);
        check(req, match, exp);
    endtask

    task automatic send_str(input string req, input string s);
        for (int i = 0; i < s.len(); i++) send(req, s[i] == "1");
    endtask

    initial begin
        rst = 1'b1;
        din = 1'b0;
        repeat (2) @(negedge clk);

        do_reset("R1");
        send_str("R7", "00101010010");
        do_reset("R1");
        send_str("R7", "11011010010");

        do_reset("R3");
        send_str("R3", "0101010101");

        do_reset("R4");
        send_str("R4", "0100");
        send_str("R5", "010010101010");

        do_reset("R4");
        send_str("R4", "1100");
        send_str("R5", "0101010");

        // reset revives detection after a lock
        do_reset("R5");
        send_str("R5", "010");

        do_reset("R6");
        for (int i = 0; i < 40; i++) send("R6", 1'b0);
        do_reset("R6");
        for (int i = 0; i < 40; i++) send("R6", 1'b1);
        send_str("R6", "010");

        // pattern must not span a reset
        do_reset("R1");
        send_str("R1", "01");
        do_reset("R1");
        send_str("R1", "0");

        for (int r = 0; r < 60; r++) begin
            do_reset("R2");
            for (int i = 0; i < 30; i++) send("R2", 1'(($urandom % 4) != 0 ? $urandom % 2 : 1));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule